// File: doc/BRIEF.md
# Modem Line Control and Interrupt Arbiter

This block is the per-channel control slice of a serial port. It holds the modem control register, which drives the active-low terminal-ready, request-to-send and general-purpose output lines. It also holds the interrupt enable register. The four active-low modem status inputs pass through a synchronizer into a modem status register. That register reports the current level of each line and a sticky change flag for each line.

Four interrupt sources are kept as pending conditions:

- receiver line error
- receive data available
- transmitter empty
- modem status change

Each source is masked by its own enable bit. The highest-priority pending source that is enabled is reported as a 4-bit identification code. The interrupt pin is asserted only when a master enable bit in the modem control register is set. That same bit drives a separate output-enable signal, which stands for the high-impedance state of the pin.

The receiver and transmitter supply single-cycle event pulses and a data-ready level. The host register interface supplies write strobes and read strobes. The serial datapath, the FIFOs and the baud generator sit outside this block.

Top module: `uart_mdm_irq_ctrl`

## Requirements
- R1: A write of `mcr_wdata` takes effect on the next clock. Bit 0 drives `dtr_n` low when 1 and high when 0. Bit 1 does the same for `rts_n`, and bit 2 for `aux_n`.
- R2: After reset, `dtr_n`, `rts_n` and `aux_n` are 1, `irq` and `irq_oe` are 0, `iid` is 4'b0001 and all four change flags in `msr[3:0]` are 0.
- R3: `irq_oe` equals the last written `mcr_wdata` bit 3. `irq` is 1 only while that bit is 1 and at least one enabled source is pending.
- R4: `ier_wdata` bits gate the sources individually. Bit 0 enables receive data available, bit 1 enables transmitter empty, bit 2 enables line error and bit 3 enables modem status. A disabled source never asserts `irq` and is never reported in `iid`.
- R5: `iid` reports the highest enabled pending source. The order, highest first, is line error (4'b0110), receive data (4'b0100), transmitter empty (4'b0010) and modem status (4'b0000). When none of them is pending, `iid` is 4'b0001.
- R6: `msr[4]`, `msr[5]`, `msr[6]` and `msr[7]` are the active-high levels of `cts_n`, `dsr_n`, `ri_n` and `cd_n`. Each appears after SYNC_STAGES clocks of synchronization.
- R7: `msr[0]`, `msr[1]` and `msr[3]` set on any change of CTS, DSR and CD respectively. `msr[2]` sets only when `ri_n` goes from 0 to 1. The modem status source is pending while any of `msr[3:0]` is 1.
- R8: A `msr_rd` pulse clears `msr[3:0]` on the next clock. If a change is detected on the same clock, the set takes priority.
- R9: A `rx_err_evt` pulse sets the line error source. It stays pending until a `lsr_rd` pulse, and a set on the same clock takes priority.
- R10: A `tx_empty_evt` pulse sets the transmitter empty source. It is cleared by `thr_wr`, or by `iid_rd` while `iid` reports transmitter empty. An `iid_rd` while a higher source is reported leaves it pending.
- R11: The receive data source is pending exactly while `rx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mcr_wr | input | 1 | Modem control register write strobe |
| mcr_wdata | input | 4 | Modem control write data (bit 0 DTR, bit 1 RTS, bit 2 aux, bit 3 interrupt output enable) |
| ier_wr | input | 1 | Interrupt enable register write strobe |
| ier_wdata | input | 4 | Interrupt enable write data |
| msr_rd | input | 1 | Modem status read strobe, clears change flags |
| lsr_rd | input | 1 | Line status read strobe, clears line error source |
| iid_rd | input | 1 | Identification read strobe |
| thr_wr | input | 1 | Transmit data write strobe, clears transmitter empty source |
| rx_err_evt | input | 1 | Receiver error event pulse |
| rx_ready | input | 1 | Receive data available level |
| tx_empty_evt | input | 1 | Transmitter empty event pulse |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| cd_n | input | 1 | Carrier detect, active low, asynchronous |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| aux_n | output | 1 | General-purpose output, active low |
| msr | output | 8 | Modem status register value |
| iid | output | 4 | Interrupt identification code |
| irq | output | 1 | Interrupt request |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The assertions check four relations on every cycle:

- a modem control write reaches the line outputs one clock later
- the interrupt never asserts without its output enable
- a pending, enabled line error always owns the identification code
- the set and clear rules of the change flags and of the line error and transmitter empty sources hold

Other behaviour can only be shown by the bench's scenarios. This covers the full mapping of enable bits onto sources and the priority among all sixteen pending combinations under every enable mask. It also covers the ring indicator setting its flag on the trailing edge only, and the conditional clear of the transmitter empty source by an identification read.

// File: rtl/mdm_irq_pkg.sv
package mdm_irq_pkg;

  // Source index order equals priority order, index 0 highest.
  localparam int NUM_SRC  = 4;
  localparam int SRC_LINE = 0;
  localparam int SRC_RXD  = 1;
  localparam int SRC_TXE  = 2;
  localparam int SRC_MDM  = 3;

  // Modem control field positions
  localparam int MCR_W       = 4;
  localparam int MCR_DTR_BIT = 0;
  localparam int MCR_RTS_BIT = 1;
  localparam int MCR_AUX_BIT = 2;
  localparam int MCR_IRQ_BIT = 3;

  // Interrupt enable field positions
  localparam int IER_W        = 4;
  localparam int IER_RXD_BIT  = 0;
  localparam int IER_TXE_BIT  = 1;
  localparam int IER_LINE_BIT = 2;
  localparam int IER_MDM_BIT  = 3;

  // Modem line index (CTS, DSR, RI, CD)
  localparam int NUM_LINES = 4;
  localparam int LN_CTS    = 0;
  localparam int LN_DSR    = 1;
  localparam int LN_RI     = 2;
  localparam int LN_CD     = 3;

  typedef enum logic [3:0] {
    IID_MDM  = 4'b0000,
    IID_NONE = 4'b0001,
    IID_TXE  = 4'b0010,
    IID_RXD  = 4'b0100,
    IID_LINE = 4'b0110
  } iid_e;

  function automatic iid_e src_code(input int idx);
    case (idx)
      SRC_LINE: return IID_LINE;
      SRC_RXD:  return IID_RXD;
      SRC_TXE:  return IID_TXE;
      default:  return IID_MDM;
    endcase
  endfunction

endpackage

// File: rtl/mdm_ctrl_regs.sv
module mdm_ctrl_regs
  import mdm_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mcr_wr_i,
  input  logic [MCR_W-1:0]   mcr_wdata_i,
  input  logic               ier_wr_i,
  input  logic [IER_W-1:0]   ier_wdata_i,
  output logic               dtr_n_o,
  output logic               rts_n_o,
  output logic               aux_n_o,
  output logic               irq_master_o,
  output logic [NUM_SRC-1:0] src_en_o
);

  logic [MCR_W-1:0] mcr_q, mcr_d;
  logic [IER_W-1:0] ier_q, ier_d;

  always_comb begin
    mcr_d = mcr_q;
    ier_d = ier_q;
    if (mcr_wr_i) mcr_d = mcr_wdata_i;
    if (ier_wr_i) ier_d = ier_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcr_q <= '0;
      ier_q <= '0;
    end else begin
      if (mcr_wr_i) mcr_q <= mcr_d;
      if (ier_wr_i) ier_q <= ier_d;
    end
  end

  // Modem lines are driven low when their control bit is set
  assign dtr_n_o      = ~mcr_q[MCR_DTR_BIT];
  assign rts_n_o      = ~mcr_q[MCR_RTS_BIT];
  assign aux_n_o      = ~mcr_q[MCR_AUX_BIT];
  assign irq_master_o = mcr_q[MCR_IRQ_BIT];

  // Reorder enable bits into priority index order
  always_comb begin
    src_en_o           = '0;
    src_en_o[SRC_LINE] = ier_q[IER_LINE_BIT];
    src_en_o[SRC_RXD]  = ier_q[IER_RXD_BIT];
    src_en_o[SRC_TXE]  = ier_q[IER_TXE_BIT];
    src_en_o[SRC_MDM]  = ier_q[IER_MDM_BIT];
  end

  AST_DTR_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_wr_i |=> (dtr_n_o == !$past(mcr_wdata_i[MCR_DTR_BIT]))); // R1
  AST_RTS_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_wr_i |=> (rts_n_o == !$past(mcr_wdata_i[MCR_RTS_BIT]))); // R1

endmodule

// File: rtl/mdm_status_trk.sv
module mdm_status_trk
  import mdm_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines_n_i,
  input  logic                 msr_rd_i,
  output logic [7:0]           msr_o,
  output logic                 mdm_pend_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][NUM_LINES-1:0] sync_q;
  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] delta_q, delta_d;
  logic [NUM_LINES-1:0] chg;
  logic [NUM_LINES-1:0] now_n;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= '1;
          else        sync_q[s] <= lines_n_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= '1;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign now_n = sync_q[LAST];

  always_comb begin
    chg         = now_n ^ prev_q;
    // Ring indicator flags only on its trailing edge (low to high on the pin)
    chg[LN_RI]  = !prev_q[LN_RI] && now_n[LN_RI];
    delta_d     = msr_rd_i ? '0 : delta_q;
    delta_d     = delta_d | chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '1;
      delta_q <= '0;
    end else begin
      prev_q  <= now_n;
      delta_q <= delta_d;
    end
  end

  assign msr_o      = {~now_n, delta_q};
  assign mdm_pend_o = |delta_q;

  AST_DCTS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (now_n[LN_CTS] != prev_q[LN_CTS]) |=> msr_o[LN_CTS]); // R7
  AST_TERI_LEAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_q[LN_RI] && !now_n[LN_RI] && (msr_rd_i || !delta_q[LN_RI])) |=> !msr_o[LN_RI]); // R7
  AST_DELTA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd_i && (now_n == prev_q)) |=> (msr_o[3:0] == 4'b0000)); // R8

endmodule

// File: rtl/irq_src_latch.sv
module irq_src_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_err_evt_i,
  input  logic lsr_rd_i,
  input  logic tx_empty_evt_i,
  input  logic thr_wr_i,
  input  logic iid_rd_i,
  input  logic txe_reported_i,
  output logic line_pend_o,
  output logic txe_pend_o
);

  logic line_q, line_d;
  logic txe_q, txe_d;

  always_comb begin
    line_d = line_q;
    if (lsr_rd_i)     line_d = 1'b0;
    if (rx_err_evt_i) line_d = 1'b1;

    txe_d = txe_q;
    if (thr_wr_i || (iid_rd_i && txe_reported_i)) txe_d = 1'b0;
    if (tx_empty_evt_i)                           txe_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      txe_q  <= 1'b0;
    end else begin
      line_q <= line_d;
      txe_q  <= txe_d;
    end
  end

  assign line_pend_o = line_q;
  assign txe_pend_o  = txe_q;

  AST_LINE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_evt_i |=> line_pend_o); // R9
  AST_LINE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd_i && !rx_err_evt_i) |=> !line_pend_o); // R9
  AST_TXE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr_i && !tx_empty_evt_i) |=> !txe_pend_o); // R10
  AST_TXE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (txe_pend_o && iid_rd_i && !txe_reported_i && !thr_wr_i) |=> txe_pend_o); // R10

endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import mdm_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               master_i,
  output logic [3:0]         iid_o,
  output logic               irq_o,
  output logic               irq_oe_o
);

  logic [NUM_SRC-1:0] hit;
  iid_e               code;

  always_comb begin
    hit  = pend_i & en_i;
    code = IID_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (hit[i]) code = src_code(i);
    end
  end

  assign iid_o    = code;
  assign irq_o    = master_i && (|hit);
  assign irq_oe_o = master_i;

endmodule

// File: rtl/uart_mdm_irq_ctrl.sv
module uart_mdm_irq_ctrl
  import mdm_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mcr_wr,
  input  logic [MCR_W-1:0] mcr_wdata,
  input  logic             ier_wr,
  input  logic [IER_W-1:0] ier_wdata,
  input  logic             msr_rd,
  input  logic             lsr_rd,
  input  logic             iid_rd,
  input  logic             thr_wr,
  input  logic             rx_err_evt,
  input  logic             rx_ready,
  input  logic             tx_empty_evt,
  input  logic             cts_n,
  input  logic             dsr_n,
  input  logic             ri_n,
  input  logic             cd_n,
  output logic             dtr_n,
  output logic             rts_n,
  output logic             aux_n,
  output logic [7:0]       msr,
  output logic [3:0]       iid,
  output logic             irq,
  output logic             irq_oe
);

  // Reset: asserted asynchronously, released after RST_STAGES clocks
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[RST_STAGES-1];

  logic               irq_master;
  logic [NUM_SRC-1:0] src_en;
  logic [NUM_SRC-1:0] pend;
  logic               mdm_pend;
  logic               line_pend;
  logic               txe_pend;
  logic [NUM_LINES-1:0] lines_n;

  always_comb begin
    lines_n         = '1;
    lines_n[LN_CTS] = cts_n;
    lines_n[LN_DSR] = dsr_n;
    lines_n[LN_RI]  = ri_n;
    lines_n[LN_CD]  = cd_n;
  end

  mdm_ctrl_regs u_regs (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .mcr_wr_i     (mcr_wr),
    .mcr_wdata_i  (mcr_wdata),
    .ier_wr_i     (ier_wr),
    .ier_wdata_i  (ier_wdata),
    .dtr_n_o      (dtr_n),
    .rts_n_o      (rts_n),
    .aux_n_o      (aux_n),
    .irq_master_o (irq_master),
    .src_en_o     (src_en)
  );

  mdm_status_trk #(.SYNC_STAGES(SYNC_STAGES)) u_status (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .lines_n_i  (lines_n),
    .msr_rd_i   (msr_rd),
    .msr_o      (msr),
    .mdm_pend_o (mdm_pend)
  );

  irq_src_latch u_src (
    .clk            (clk),
    .rst_n          (core_rst_n),
    .rx_err_evt_i   (rx_err_evt),
    .lsr_rd_i       (lsr_rd),
    .tx_empty_evt_i (tx_empty_evt),
    .thr_wr_i       (thr_wr),
    .iid_rd_i       (iid_rd),
    .txe_reported_i (iid == IID_TXE),
    .line_pend_o    (line_pend),
    .txe_pend_o     (txe_pend)
  );

  always_comb begin
    pend           = '0;
    pend[SRC_LINE] = line_pend;
    pend[SRC_RXD]  = rx_ready;
    pend[SRC_TXE]  = txe_pend;
    pend[SRC_MDM]  = mdm_pend;
  end

  irq_prio u_prio (
    .pend_i   (pend),
    .en_i     (src_en),
    .master_i (irq_master),
    .iid_o    (iid),
    .irq_o    (irq),
    .irq_oe_o (irq_oe)
  );

  AST_IRQ_NEEDS_OE: assert property (@(posedge clk) disable iff (!core_rst_n)
    irq |-> irq_oe); // R3
  AST_OE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!core_rst_n)
    mcr_wr |=> (irq_oe == $past(mcr_wdata[MCR_IRQ_BIT]))); // R3
  AST_LINE_OWNS_IID: assert property (@(posedge clk) disable iff (!core_rst_n)
    (line_pend && src_en[SRC_LINE]) |-> (iid == IID_LINE)); // R5
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!core_rst_n)
    (iid == IID_NONE) |-> !irq); // R5

endmodule

// File: tb/uart_mdm_irq_ctrl_bench.sv
module uart_mdm_irq_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mcr_wr, ier_wr, msr_rd, lsr_rd, iid_rd, thr_wr;
  logic [3:0] mcr_wdata, ier_wdata;
  logic       rx_err_evt, rx_ready, tx_empty_evt;
  logic       cts_n, dsr_n, ri_n, cd_n;
  logic       dtr_n, rts_n, aux_n, irq, irq_oe;
  logic [7:0] msr;
  logic [3:0] iid;

  int vectors     = 0;
  int miscompares = 0;

  always #4 clk = ~clk; // 125 MHz

  uart_mdm_irq_ctrl u_uart_mdm_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .mcr_wr(mcr_wr), .mcr_wdata(mcr_wdata),
    .ier_wr(ier_wr), .ier_wdata(ier_wdata), .msr_rd(msr_rd), .lsr_rd(lsr_rd),
    .iid_rd(iid_rd), .thr_wr(thr_wr), .rx_err_evt(rx_err_evt), .rx_ready(rx_ready),
    .tx_empty_evt(tx_empty_evt), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .cd_n(cd_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .aux_n(aux_n), .msr(msr), .iid(iid),
    .irq(irq), .irq_oe(irq_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mcr(input logic [3:0] d);
    mcr_wdata = d; mcr_wr = 1'b1; tick(1); mcr_wr = 1'b0;
  endtask

  task automatic wr_ier(input logic [3:0] d);
    ier_wdata = d; ier_wr = 1'b1; tick(1); ier_wr = 1'b0;
  endtask

  // Expected code from pending (bit0 line, bit1 rxd, bit2 txe, bit3 mdm) and enables
  function automatic logic [3:0] exp_iid(input logic [3:0] p, input logic [3:0] ier);
    logic [3:0] en;
    logic [3:0] h;
    en = {ier[3], ier[1], ier[0], ier[2]};
    h  = p & en;
    if (h[0])      return 4'b0110;
    else if (h[1]) return 4'b0100;
    else if (h[2]) return 4'b0010;
    else if (h[3]) return 4'b0000;
    return 4'b0001;
  endfunction

  function automatic logic exp_irq(input logic [3:0] p, input logic [3:0] ier, input logic m);
    logic [3:0] en;
    en = {ier[3], ier[1], ier[0], ier[2]};
    return m && (|(p & en));
  endfunction

  task automatic clear_all();
    lsr_rd = 1'b1; thr_wr = 1'b1; rx_ready = 1'b0; msr_rd = 1'b1;
    tick(1);
    lsr_rd = 1'b0; thr_wr = 1'b0; msr_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    mcr_wr = 0; ier_wr = 0; msr_rd = 0; lsr_rd = 0; iid_rd = 0; thr_wr = 0;
    mcr_wdata = 0; ier_wdata = 0;
    rx_err_evt = 0; rx_ready = 0; tx_empty_evt = 0;
    cts_n = 1; dsr_n = 1; ri_n = 1; cd_n = 1;
    tick(3);
    rst_n = 1'b1;
    tick(6);

    // R2: reset state
    chk("R2 dtr_n", dtr_n, 1);
    chk("R2 rts_n", rts_n, 1);
    chk("R2 aux_n", aux_n, 1);
    chk("R2 irq", irq, 0);
    chk("R2 irq_oe", irq_oe, 0);
    chk("R2 iid", iid, 4'b0001);
    chk("R2 msr deltas", msr[3:0], 0);

    // R1: every combination of the three line bits
    for (int v = 0; v < 8; v++) begin
      wr_mcr(v[3:0]);
      chk("R1 dtr_n", dtr_n, !v[0]);
      chk("R1 rts_n", rts_n, !v[1]);
      chk("R1 aux_n", aux_n, !v[2]);
      chk("R3 irq_oe off", irq_oe, 0);
    end

    // R6/R7/R8: each modem line
    for (int ln = 0; ln < 4; ln++) begin
      case (ln)
        0: cts_n = 0;
        1: dsr_n = 0;
        2: ri_n  = 0;
        default: cd_n = 0;
      endcase
      tick(4);
      chk("R6 level active", msr[4+ln], 1);
      chk("R7 delta on assert", msr[ln], (ln == 2) ? 0 : 1);
      msr_rd = 1; tick(1); msr_rd = 0;
      chk("R8 delta cleared", msr[3:0], 0);
      case (ln)
        0: cts_n = 1;
        1: dsr_n = 1;
        2: ri_n  = 1;
        default: cd_n = 1;
      endcase
      tick(4);
      chk("R6 level idle", msr[4+ln], 0);
      chk("R7 delta on release", msr[3:0], 4'b0001 << ln);
      msr_rd = 1; tick(1); msr_rd = 0;
      chk("R8 delta cleared again", msr[3:0], 0);
    end

    // R3/R4/R5/R7/R9/R10/R11: exhaustive sweep of master, enables and pending set
    for (int m = 0; m < 2; m++) begin
      for (int e = 0; e < 16; e++) begin
        for (int p = 0; p < 16; p++) begin
          wr_mcr({m[0], 3'b000});
          wr_ier(e[3:0]);
          rx_ready     = p[1];
          rx_err_evt   = p[0];
          tx_empty_evt = p[2];
          if (p[3]) cts_n = ~cts_n;
          tick(1);
          rx_err_evt = 0; tx_empty_evt = 0;
          tick(4);
          chk("R5 R4 iid sweep", iid, exp_iid(p[3:0], e[3:0]));
          chk("R3 R4 irq sweep", irq, exp_irq(p[3:0], e[3:0], m[0]));
          chk("R3 irq_oe sweep", irq_oe, m[0]);
          clear_all();
          chk("R9 R10 R11 R8 cleared", iid, 4'b0001);
        end
      end
    end
    if (cts_n == 0) begin
      cts_n = 1; tick(4); clear_all();
    end

    // R10: identification read clears transmitter empty only when reported
    wr_mcr(4'b1000);
    wr_ier(4'b0110);
    tx_empty_evt = 1; tick(1); tx_empty_evt = 0;
    chk("R10 txe reported", iid, 4'b0010);
    iid_rd = 1; tick(1); iid_rd = 0;
    chk("R10 iid_rd clears txe", iid, 4'b0001);
    chk("R10 irq released", irq, 0);

    tx_empty_evt = 1; rx_err_evt = 1; tick(1); tx_empty_evt = 0; rx_err_evt = 0;
    chk("R5 line over txe", iid, 4'b0110);
    iid_rd = 1; tick(1); iid_rd = 0;
    lsr_rd = 1; tick(1); lsr_rd = 0;
    chk("R10 txe kept after shadowed read", iid, 4'b0010);

    // R9: set and clear on the same clock, set wins
    rx_err_evt = 1; lsr_rd = 1; tick(1); rx_err_evt = 0; lsr_rd = 0;
    chk("R9 set wins", iid, 4'b0110);
    lsr_rd = 1; tick(1); lsr_rd = 0;
    thr_wr = 1; tick(1); thr_wr = 0;
    chk("R9 R10 both cleared", iid, 4'b0001);

    // R4: disabled source stays out of irq while master is on
    wr_ier(4'b0000);
    rx_ready = 1; tick(1);
    chk("R4 R11 masked rxd irq", irq, 0);
    chk("R4 R11 masked rxd iid", iid, 4'b0001);
    wr_ier(4'b0001);
    chk("R11 rxd enabled", iid, 4'b0100);
    chk("R3 irq asserted", irq, 1);
    wr_mcr(4'b0000);
    chk("R3 master off", irq, 0);
    rx_ready = 0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule